// File: doc/BRIEF.md
# Stop-Mode Standby Power Controller

This block sequences a microcontroller core into and out of its deepest clock-stopped standby state. A one-cycle pulse from the instruction decoder requests the state. The block then turns the main oscillator off and freezes the CPU. It keeps a small set of peripheral clock enables alive, and each of these depends on where that peripheral takes its clock from. Any interrupt whose request bit is set and whose mask bit is clear ends the standby.

On wake the oscillator is restarted at once, but the CPU is held in a halted phase. It stays there until a selectable stabilization count has run out, and only then resumes. The block also owns the port output latch, which freezes its contents for as long as the CPU is not running. The mode is reported on a 2-bit status output.

Top module: `stby_stop_ctrl`

## Requirements
- R1: After a synchronous active-low reset the mode is RUN. `osc_en` and `cpu_run` are 1, `halt_st` is 0 and `port_out` is all zeros.
- R2: A `stop_req` pulse in RUN with no live interrupt moves the block to STOP on the next clock. In STOP, `osc_en` and `cpu_run` are both 0.
- R3: In STOP, any bit with `irq_req`=1 and `irq_mask`=0 moves the block to HALT_WAIT on the next clock. Requests whose mask bit is 1 have no effect.
- R4: If a live interrupt is present on the cycle that `stop_req` is seen in RUN, the block goes straight to HALT_WAIT and never shows STOP.
- R5: In HALT_WAIT, `osc_en`=1, `cpu_run`=0 and `halt_st`=1. The phase lasts exactly 2^(BASE_EXP+k) clocks. k is 0, 2, 3, 4 or 5 for `stab_sel` codes 0, 1, 2, 3 and 4, and codes 5 to 7 act as code 4. The code is captured on the clock that enters HALT_WAIT.
- R6: During HALT_WAIT, new interrupts, `stop_req` pulses and changes of `stab_sel` neither shorten nor lengthen the wait. In STOP, `stop_req` is ignored.
- R7: `port_wr_data` is written into `port_out` on a clock where the mode is RUN and `port_wr_en`=1. In STOP and HALT_WAIT, writes are ignored and `port_out` holds its value.
- R8: In RUN, every peripheral enable output is 1.
- R9: Outside RUN, `en_tmr16`, `en_wdt` and `en_adc` are 0.
- R10: Outside RUN, `en_watch`, `en_tmr8` and `en_disp` equal `sub_clk_run` AND `sub_clk_sel`.
- R11: Outside RUN, `en_evt[i]` equals `evt_src_ext[i]` and `en_ser` equals `ser_ext_clk`.
- R12: Outside RUN, `en_cmp` is 1 when `sub_clk_run`=0. When `sub_clk_run`=1 it is 1 only if the 8-bit timer is kept enabled.
- R13: `mode_st` encodes RUN as 2'b00, STOP as 2'b01 and HALT_WAIT as 2'b10. The value 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stop_req | input | 1 | One-cycle stop instruction pulse |
| irq_req | input | N_IRQ | Interrupt request flags |
| irq_mask | input | N_IRQ | Interrupt mask flags, 1 = masked |
| sub_clk_run | input | 1 | Subsystem clock oscillating |
| sub_clk_sel | input | 1 | Subsystem clock chosen as the timer/display source |
| ser_ext_clk | input | 1 | Serial unit clocked from its external pin |
| evt_src_ext | input | N_EVT | Per event counter: external count input selected |
| stab_sel | input | 3 | Stabilization wait code |
| port_wr_en | input | 1 | Port latch write strobe |
| port_wr_data | input | PORT_W | Port latch write data |
| osc_en | output | 1 | Main oscillator enable |
| cpu_run | output | 1 | CPU executing |
| halt_st | output | 1 | In HALT_WAIT |
| mode_st | output | 2 | Current mode code |
| en_tmr16 | output | 1 | 16-bit timer clock enable |
| en_wdt | output | 1 | Watchdog clock enable |
| en_adc | output | 1 | A/D converter enable |
| en_watch | output | 1 | Watch timer enable |
| en_tmr8 | output | 1 | 8-bit timer enable |
| en_disp | output | 1 | Display driver enable |
| en_evt | output | N_EVT | Event counter enables |
| en_ser | output | 1 | Serial interface enable |
| en_cmp | output | 1 | Comparator enable |
| port_out | output | PORT_W | Port output latch |

## Verification
The embedded assertions watch several rules on every clock:
- STOP entry and wake transitions, and the legal mode codes.
- That HALT_WAIT never ends before the counter reaches its terminal value, and that the counter stays within its bound.
- That the port latch is frozen outside RUN.
- That the deep-off peripherals are dark outside RUN, and the comparator's dependence on the 8-bit timer.

The exact HALT_WAIT length for each code, the capture of the code at entry, and the direct jump into HALT_WAIT when an interrupt is already pending can only be shown by the bench scenarios. The same holds for the full enable truth table across clock-source combinations. The bench checks these against its cycle model.

// File: rtl/stby_pkg.sv
// Shared types and helpers for the stop-mode standby controller.
// Assumes: stabilization codes above 4 saturate to the longest wait.
package stby_pkg;

    typedef enum logic [1:0] {
        PM_RUN  = 2'b00,
        PM_STOP = 2'b01,
        PM_HALT = 2'b10
    } pm_state_e;

    // Largest exponent offset a code can select.
    localparam int unsigned STAB_MAX_OFS = 5;

    // Map a wait code to its exponent offset over the base exponent.
    function automatic int unsigned stab_offset(input logic [2:0] code);
        case (code)
            3'd0:    stab_offset = 0;
            3'd1:    stab_offset = 2;
            3'd2:    stab_offset = 3;
            3'd3:    stab_offset = 4;
            default: stab_offset = STAB_MAX_OFS;
        endcase
    endfunction

endpackage

// File: rtl/stby_wake_detect.sv
// Reduces the interrupt request and mask vectors to one wake flag.
// Assumes: mask bit 1 blocks its source; purely combinational.
module stby_wake_detect #(
    parameter int N_IRQ = 8
) (
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_mask,
    output logic             wake_pend
);

    logic [N_IRQ-1:0] live;

    // Qualify each source by its mask bit.
    generate
        for (genvar g = 0; g < N_IRQ; g++) begin : g_src
            assign live[g] = irq_req[g] & ~irq_mask[g];
        end
    endgenerate

    assign wake_pend = |live;

endmodule

// File: rtl/stby_stab_timer.sv
// Oscillator stabilization counter used during HALT_WAIT.
// Captures the wait code on load and raises done on the last cycle of the wait.
// Assumes: load coincides with the clock that enters HALT_WAIT; active is high
// for exactly the cycles spent in HALT_WAIT.
module stby_stab_timer
    import stby_pkg::*;
#(
    parameter int BASE_EXP = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       active,
    input  logic [2:0] sel,
    output logic       done
);

    localparam int MAX_EXP = BASE_EXP + int'(STAB_MAX_OFS);
    localparam int CW      = MAX_EXP + 1;
    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    assign done = active && (cnt == last);

    // Count while waiting; clear and capture the terminal value on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            last <= '0;
        end else if (load) begin
            cnt  <= '0;
            last <= (ONE << (BASE_EXP + int'(stab_offset(sel)))) - ONE;
        end else if (active && !done) begin
            cnt <= cnt + ONE;
        end else if (!active) begin
            cnt <= '0;
        end
    end

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt <= last));

    // R6
    count_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !done && !load) |=> (cnt == $past(cnt) + ONE));

endmodule

// File: rtl/stby_mode_fsm.sv
// Three-state standby sequencer: RUN, STOP and HALT_WAIT.
// Assumes: stop_req is a one-cycle pulse; stab_done is only high in HALT_WAIT.
module stby_mode_fsm
    import stby_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      stop_req,
    input  logic      wake_pend,
    input  logic      stab_done,
    output pm_state_e state,
    output logic      halt_entry
);

    pm_state_e nxt;

    // Next-state selection and the HALT_WAIT entry strobe.
    always_comb begin
        nxt        = state;
        halt_entry = 1'b0;
        case (state)
            PM_RUN: begin
                if (stop_req) begin
                    if (wake_pend) begin
                        nxt        = PM_HALT;
                        halt_entry = 1'b1;
                    end else begin
                        nxt = PM_STOP;
                    end
                end
            end
            PM_STOP: begin
                if (wake_pend) begin
                    nxt        = PM_HALT;
                    halt_entry = 1'b1;
                end
            end
            PM_HALT: begin
                if (stab_done) nxt = PM_RUN;
            end
            default: nxt = PM_RUN;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PM_RUN;
        else        state <= nxt;
    end

    // R2
    stop_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PM_RUN && stop_req && !wake_pend) |=> (state == PM_STOP));

    // R3
    wake_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PM_STOP && wake_pend) |=> (state == PM_HALT));

    // R3
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PM_STOP && !wake_pend) |=> (state == PM_STOP));

    // R4
    direct_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PM_RUN && stop_req && wake_pend) |=> (state == PM_HALT));

    // R6
    no_early_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PM_HALT && !stab_done) |=> (state == PM_HALT));

    // R13
    legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state != 2'b11);

endmodule

// File: rtl/stby_clk_gate_ctrl.sv
// Derives per-peripheral clock enables from the mode and clock-source selects.
// Assumes: in RUN every peripheral is clocked; outside RUN only sources that
// do not depend on the main oscillator keep a unit alive.
module stby_clk_gate_ctrl #(
    parameter int N_EVT = 2
) (
    input  logic             run_mode,
    input  logic             sub_clk_run,
    input  logic             sub_clk_sel,
    input  logic             ser_ext_clk,
    input  logic [N_EVT-1:0] evt_src_ext,
    output logic             en_tmr16,
    output logic             en_wdt,
    output logic             en_adc,
    output logic             en_watch,
    output logic             en_tmr8,
    output logic             en_disp,
    output logic [N_EVT-1:0] en_evt,
    output logic             en_ser,
    output logic             en_cmp
);

    logic sub_ok;

    // Subsystem clock usable as a standby source only when running and chosen.
    always_comb sub_ok = sub_clk_run & sub_clk_sel;

    // Units that need the main clock; dark whenever the CPU is not running.
    always_comb begin
        en_tmr16 = run_mode;
        en_wdt   = run_mode;
        en_adc   = run_mode;
    end

    // Units that can run from the subsystem clock.
    always_comb begin
        en_watch = run_mode | sub_ok;
        en_tmr8  = run_mode | sub_ok;
        en_disp  = run_mode | sub_ok;
    end

    // Event counters survive standby only with an external count input.
    generate
        for (genvar e = 0; e < N_EVT; e++) begin : g_evt
            assign en_evt[e] = run_mode | evt_src_ext[e];
        end
    endgenerate

    // Serial unit needs an external shift clock; the comparator acts as a wake source
    // and needs the 8-bit timer when the subsystem clock is running.
    always_comb begin
        en_ser = run_mode | ser_ext_clk;
        en_cmp = run_mode | ~sub_clk_run | sub_ok;
    end

endmodule

// File: rtl/stby_stop_ctrl.sv
// Top of the stop-mode standby controller: mode sequencer, stabilization
// counter, peripheral clock-enable logic and the frozen port output latch.
// Assumes: single clock domain; stop_req is one cycle; synchronous active-low reset.
module stby_stop_ctrl
    import stby_pkg::*;
#(
    parameter int N_IRQ    = 8,
    parameter int N_EVT    = 2,
    parameter int PORT_W   = 8,
    parameter int BASE_EXP = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stop_req,
    input  logic [N_IRQ-1:0]  irq_req,
    input  logic [N_IRQ-1:0]  irq_mask,
    input  logic              sub_clk_run,
    input  logic              sub_clk_sel,
    input  logic              ser_ext_clk,
    input  logic [N_EVT-1:0]  evt_src_ext,
    input  logic [2:0]        stab_sel,
    input  logic              port_wr_en,
    input  logic [PORT_W-1:0] port_wr_data,
    output logic              osc_en,
    output logic              cpu_run,
    output logic              halt_st,
    output logic [1:0]        mode_st,
    output logic              en_tmr16,
    output logic              en_wdt,
    output logic              en_adc,
    output logic              en_watch,
    output logic              en_tmr8,
    output logic              en_disp,
    output logic [N_EVT-1:0]  en_evt,
    output logic              en_ser,
    output logic              en_cmp,
    output logic [PORT_W-1:0] port_out
);

    pm_state_e         state;
    logic              wake_pend;
    logic              halt_entry;
    logic              stab_done;
    logic              in_run;
    logic [PORT_W-1:0] port_q;

    stby_wake_detect #(.N_IRQ(N_IRQ)) u_wake (
        .irq_req   (irq_req),
        .irq_mask  (irq_mask),
        .wake_pend (wake_pend)
    );

    stby_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .stop_req   (stop_req),
        .wake_pend  (wake_pend),
        .stab_done  (stab_done),
        .state      (state),
        .halt_entry (halt_entry)
    );

    stby_stab_timer #(.BASE_EXP(BASE_EXP)) u_stab (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (halt_entry),
        .active (state == PM_HALT),
        .sel    (stab_sel),
        .done   (stab_done)
    );

    // Mode decode for the status outputs.
    always_comb begin
        in_run  = (state == PM_RUN);
        osc_en  = (state != PM_STOP);
        cpu_run = in_run;
        halt_st = (state == PM_HALT);
        mode_st = state;
    end

    stby_clk_gate_ctrl #(.N_EVT(N_EVT)) u_gate (
        .run_mode    (in_run),
        .sub_clk_run (sub_clk_run),
        .sub_clk_sel (sub_clk_sel),
        .ser_ext_clk (ser_ext_clk),
        .evt_src_ext (evt_src_ext),
        .en_tmr16    (en_tmr16),
        .en_wdt      (en_wdt),
        .en_adc      (en_adc),
        .en_watch    (en_watch),
        .en_tmr8     (en_tmr8),
        .en_disp     (en_disp),
        .en_evt      (en_evt),
        .en_ser      (en_ser),
        .en_cmp      (en_cmp)
    );

    // Port output latch: written only while the CPU runs.
    always_ff @(posedge clk) begin
        if (!rst_n)                  port_q <= '0;
        else if (in_run && port_wr_en) port_q <= port_wr_data;
    end

    assign port_out = port_q;

    // R7
    port_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_run |=> $stable(port_out));

    // R9
    deep_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_run |-> !(en_tmr16 || en_wdt || en_adc));

    // R12
    cmp_needs_tmr8_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_run && sub_clk_run && en_cmp) |-> en_tmr8);

    // R5
    halt_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_st |-> (osc_en && !cpu_run));

endmodule

// File: tb/tb_stby_stop_ctrl.sv
`timescale 1ns/1ps
module tb_stby_stop_ctrl;

    localparam int N_IRQ = 8;
    localparam int N_EVT = 2;
    localparam int PW    = 8;
    localparam int BEXP  = 2;

    logic clk = 1'b0;
    logic rst_n;
    logic stop_req;
    logic [N_IRQ-1:0] irq_req, irq_mask;
    logic sub_clk_run, sub_clk_sel, ser_ext_clk;
    logic [N_EVT-1:0] evt_src_ext;
    logic [2:0] stab_sel;
    logic port_wr_en;
    logic [PW-1:0] port_wr_data;
    logic osc_en, cpu_run, halt_st;
    logic [1:0] mode_st;
    logic en_tmr16, en_wdt, en_adc, en_watch, en_tmr8, en_disp, en_ser, en_cmp;
    logic [N_EVT-1:0] en_evt;
    logic [PW-1:0] port_out;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit started = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    stby_stop_ctrl #(.N_IRQ(N_IRQ), .N_EVT(N_EVT), .PORT_W(PW), .BASE_EXP(BEXP)) dut (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .irq_req(irq_req),
        .irq_mask(irq_mask), .sub_clk_run(sub_clk_run), .sub_clk_sel(sub_clk_sel),
        .ser_ext_clk(ser_ext_clk), .evt_src_ext(evt_src_ext), .stab_sel(stab_sel),
        .port_wr_en(port_wr_en), .port_wr_data(port_wr_data), .osc_en(osc_en),
        .cpu_run(cpu_run), .halt_st(halt_st), .mode_st(mode_st), .en_tmr16(en_tmr16),
        .en_wdt(en_wdt), .en_adc(en_adc), .en_watch(en_watch), .en_tmr8(en_tmr8),
        .en_disp(en_disp), .en_evt(en_evt), .en_ser(en_ser), .en_cmp(en_cmp),
        .port_out(port_out)
    );

    // Expected wait length from the requirement table.
    function automatic int wait_len(input logic [2:0] code);
        int k;
        case (code)
            3'd0: k = 0;
            3'd1: k = 2;
            3'd2: k = 3;
            3'd3: k = 4;
            default: k = 5;
        endcase
        return 1 << (BEXP + k);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference: 0 = RUN, 1 = STOP, 2 = HALT_WAIT.
    int m_state = 0, m_cnt = 0, m_lim = 1, m_port = 0;
    always @(posedge clk) begin
        bit pend;
        started <= 1'b1;
        cycles++;
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; m_port = 0;
        end else begin
            pend = (irq_req & ~irq_mask) != 0;
            if (m_state == 0 && port_wr_en) m_port = int'(port_wr_data);
            case (m_state)
                0: if (stop_req) begin
                       if (pend) begin m_state = 2; m_cnt = 0; m_lim = wait_len(stab_sel); end
                       else m_state = 1;
                   end
                1: if (pend) begin m_state = 2; m_cnt = 0; m_lim = wait_len(stab_sel); end
                default: if (m_cnt == m_lim - 1) m_state = 0; else m_cnt++;
            endcase
        end
    end

    // Compare every output with the model each cycle, away from the clock edge.
    always @(negedge clk) begin
        if (started && !finished) begin
            bit run, sub_ok;
            run = (m_state == 0);
            sub_ok = sub_clk_run && sub_clk_sel;
            chk(mode_st == m_state[1:0], "R13", "mode_st", int'(mode_st), m_state);
            chk(osc_en == (m_state != 1), "R2", "osc_en", int'(osc_en), int'(m_state != 1));
            chk(cpu_run == run, "R2", "cpu_run", int'(cpu_run), int'(run));
            chk(halt_st == (m_state == 2), "R5", "halt_st", int'(halt_st), int'(m_state == 2));
            chk({en_tmr16, en_wdt, en_adc} == {3{run}}, "R9 R8", "deep enables",
                int'({en_tmr16, en_wdt, en_adc}), run ? 7 : 0);
            chk({en_watch, en_tmr8, en_disp} == {3{run | sub_ok}}, "R10 R8", "sub enables",
                int'({en_watch, en_tmr8, en_disp}), (run | sub_ok) ? 7 : 0);
            chk(en_evt == (run ? {N_EVT{1'b1}} : evt_src_ext), "R11", "en_evt",
                int'(en_evt), int'(run ? {N_EVT{1'b1}} : evt_src_ext));
            chk(en_ser == (run | ser_ext_clk), "R11", "en_ser", int'(en_ser), int'(run | ser_ext_clk));
            chk(en_cmp == (run | !sub_clk_run | sub_ok), "R12", "en_cmp",
                int'(en_cmp), int'(run | !sub_clk_run | sub_ok));
            chk(int'(port_out) == m_port, "R7", "port_out", int'(port_out), m_port);
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic summary();
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(4 * 190000);
        n_tests++; n_fail++;
        $display("FAIL R6 watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        rst_n = 0; stop_req = 0; irq_req = '0; irq_mask = '1;
        sub_clk_run = 0; sub_clk_sel = 0; ser_ext_clk = 0; evt_src_ext = '0;
        stab_sel = 3'd0; port_wr_en = 0; port_wr_data = '0;
        step(3);
        @(negedge clk);
        chk(mode_st == 2'b00 && osc_en && cpu_run && !halt_st && port_out == '0,
            "R1", "reset state", int'(mode_st), 0);
        @(posedge clk); #1;
        rst_n = 1;

        // R7: write in RUN lands on the next clock.
        port_wr_en = 1; port_wr_data = 8'hA5;
        step(1);
        port_wr_en = 0;
        @(negedge clk);
        chk(port_out == 8'hA5, "R7", "run write", int'(port_out), 8'hA5);

        for (int i = 0; i < 6; i++) begin
            logic [2:0] code;
            int len;
            code = (i == 5) ? 3'd7 : 3'(i);
            stab_sel = code;
            sub_clk_run = i[0]; sub_clk_sel = i[1]; ser_ext_clk = i[2];
            evt_src_ext = 2'(i);
            @(posedge clk); #1;
            stop_req = 1;
            step(1);
            stop_req = 0;
            @(negedge clk);
            chk(mode_st == 2'b01 && !osc_en && !cpu_run, "R2", "enter STOP", int'(mode_st), 1);
            @(posedge clk); #1;
            // R3: masked requests, a stop pulse and a port write have no effect.
            irq_req = 8'h0F; stop_req = 1; port_wr_en = 1; port_wr_data = 8'(i + 3);
            step(1);
            stop_req = 0; port_wr_en = 0;
            step(4);
            @(negedge clk);
            chk(mode_st == 2'b01, "R3", "masked ignored", int'(mode_st), 1);
            chk(port_out == 8'hA5, "R7", "stop write ignored", int'(port_out), 8'hA5);
            @(posedge clk); #1;
            irq_mask = ~8'h04;
            step(1);
            @(negedge clk);
            chk(mode_st == 2'b10 && halt_st && osc_en && !cpu_run, "R3", "wake to HALT",
                int'(mode_st), 2);
            // R6: changing code, new irqs and stop pulses do not alter the wait.
            stab_sel = 3'd0; irq_req = 8'hFF; stop_req = 1;
            len = 1;
            @(posedge clk); #1;
            stop_req = 0;
            forever begin
                @(negedge clk);
                if (!halt_st) break;
                len++;
            end
            chk(len == wait_len(code), "R5", "halt length", len, wait_len(code));
            chk(mode_st == 2'b00 && cpu_run, "R6", "back to RUN", int'(mode_st), 0);
            @(posedge clk); #1;
            irq_req = '0; irq_mask = '1;
        end

        // R4: live interrupt at the stop request skips STOP.
        stab_sel = 3'd1; irq_req = 8'h80; irq_mask = 8'h7F;
        stop_req = 1;
        step(1);
        stop_req = 0;
        @(negedge clk);
        chk(mode_st == 2'b10, "R4", "direct HALT", int'(mode_st), 2);
        @(posedge clk); #1;
        irq_req = '0;
        step(wait_len(3'd1) + 2);
        @(negedge clk);
        chk(mode_st == 2'b00, "R4", "resume after direct", int'(mode_st), 0);

        // R7: writes work again after resuming.
        @(posedge clk); #1;
        port_wr_en = 1; port_wr_data = 8'h3C;
        step(1);
        port_wr_en = 0;
        @(negedge clk);
        chk(port_out == 8'h3C, "R7", "write after resume", int'(port_out), 8'h3C);
        step(2);
        summary();
    end

endmodule